// File: doc/BRIEF.md
# Exception Vector and Status Control

This block keeps the processor's status control bits and, every cycle, turns the pending exception and interrupt requests into one exception entry address. Software updates the status byte through a write port. Reset and a non-maskable interrupt both force the boot-vector bit on. That bit moves the entry addresses from the normal region at 0xFFFF_FFFF_8000_0000 to the boot region at 0xFFFF_FFFF_BFC0_0000.

Per-privilege widening bits choose an extended TLB-miss entry for misses on addresses of the matching segment. The same bits also report whether each privilege level may use the 64-bit opcode set. Requests are ranked, and only one cause wins in a cycle. The vector and the cause flags come from combinational logic driven by the present inputs and the stored status. Status changes take effect at the next rising clock edge.

Status byte layout: bit 0 interrupt enable, bit 1 kernel widening, bit 2 supervisor widening, bit 3 user widening, bit 4 reverse endian (always reads 0), bit 5 boot vector, bit 6 parity-exception mask, bit 7 cache check (stored, no effect). Privilege and segment codes: 0 kernel, 1 supervisor, 2 user, 3 reserved.

Top module: `exc_vec_ctl`

## Requirements
- R1: While reset is low and after it is released, the status byte reads 0x20 (only the boot-vector bit set). With no request pending, vec_valid is 0 and vec_addr is 0.
- R2: A status write takes effect at the next rising edge and is read back on st_rd. Bit 4 always reads 0, whatever value is written to it.
- R3: nmi_req outranks every other request and gives vector 0xFFFF_FFFF_BFC0_0000. Status bit 5 is set at the next edge, even if a write in the same cycle clears it.
- R4: With bit 5 = 1, a TLB miss gives 0xFFFF_FFFF_BFC0_0200. A general exception, an unmasked parity error or an accepted interrupt gives 0xFFFF_FFFF_BFC0_0380.
- R5: With bit 5 = 0, a TLB miss gives 0xFFFF_FFFF_8000_0000. A general exception, an unmasked parity error or an accepted interrupt gives 0xFFFF_FFFF_8000_0180.
- R6: A selected TLB miss uses the expanded vector (normal miss vector + 0x80) and raises wide_miss when the widening bit for miss_seg is set: segment 0 uses bit 1, segment 1 uses bit 2, segment 2 uses bit 3. Segment 3 never expands.
- R7: op64_ok[0] (kernel) is always 1, op64_ok[1] equals bit 2 and op64_ok[2] equals bit 3. op64_cur gives the entry for priv_mode, and gives 0 for code 3.
- R8: With bit 0 = 0 no interrupt is taken. With bit 0 = 1, any set irq_pend line with no higher request raises irq_take.
- R9: With bit 6 = 1 a parity error request never raises par_raise and gives no vector. With bit 6 = 0 it raises par_raise when no higher request is present.
- R10: Ranking is NMI, TLB miss, general exception, parity error, interrupt. At most one of wide_miss, par_raise and irq_take is 1 in any cycle.
- R11: Status bit 7 is stored and read back but changes no vector, flag or opcode permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 8 | Status write value |
| st_rd | output | 8 | Current status byte |
| priv_mode | input | 2 | Current privilege: 0 kernel, 1 supervisor, 2 user |
| miss_req | input | 1 | TLB-miss exception request |
| miss_seg | input | 2 | Segment of the missing address: 0 kernel, 1 supervisor, 2 user |
| exc_req | input | 1 | General exception request |
| par_err_req | input | 1 | Cache parity error request |
| irq_pend | input | IRQ_W | Pending maskable interrupt lines |
| nmi_req | input | 1 | Non-maskable interrupt event |
| vec_valid | output | 1 | A cause was selected this cycle |
| vec_addr | output | VA_W | Exception entry address |
| wide_miss | output | 1 | Expanded TLB-miss vector chosen |
| irq_take | output | 1 | Interrupt accepted |
| par_raise | output | 1 | Parity exception raised |
| op64_ok | output | 3 | 64-bit opcodes allowed for kernel, supervisor, user |
| op64_cur | output | 1 | 64-bit opcodes allowed for priv_mode |

## Verification
On every cycle, the assertions check that the reverse-endian bit stays 0 and that a write lands on the following edge. They also check that an NMI forces the boot bit and the boot-region entry, that wide_miss, par_raise and irq_take never appear together, and that each flag only appears when its enable and request allow it. The exact entry addresses for every boot-bit, widening-bit, segment and privilege combination can only be shown by the bench. The bench compares them with its reference model, together with the ranking between simultaneous requests and the lack of any effect from the cache-check bit.

// File: rtl/exc_vec_pkg.sv
`timescale 1ns/1ps
package exc_vec_pkg;
   localparam int unsigned STAT_W = 8;

   // status bit positions
   localparam int unsigned SB_INTEN  = 0;
   localparam int unsigned SB_KWIDE  = 1;
   localparam int unsigned SB_SWIDE  = 2;
   localparam int unsigned SB_UWIDE  = 3;
   localparam int unsigned SB_REVEND = 4;
   localparam int unsigned SB_BOOTV  = 5;
   localparam int unsigned SB_PARMSK = 6;
   localparam int unsigned SB_CCHK   = 7;

   localparam logic [STAT_W-1:0] STAT_RST = 8'h20;

   localparam logic [31:0] BOOT_BASE = 32'hBFC0_0000;
   localparam logic [31:0] NORM_BASE = 32'h8000_0000;
   localparam logic [31:0] BOOT_MISS = 32'h0000_0200;
   localparam logic [31:0] NORM_MISS = 32'h0000_0000;
   localparam logic [31:0] GEN_OFF   = 32'h0000_0180;
   localparam logic [31:0] WIDE_OFF  = 32'h0000_0080;

   typedef enum logic [1:0] {
      PRIV_KERN = 2'd0,
      PRIV_SUP  = 2'd1,
      PRIV_USR  = 2'd2,
      PRIV_RSVD = 2'd3
   } priv_e;

   typedef enum logic [2:0] {
      CAUSE_NONE = 3'd0,
      CAUSE_NMI  = 3'd1,
      CAUSE_MISS = 3'd2,
      CAUSE_EXC  = 3'd3,
      CAUSE_PAR  = 3'd4,
      CAUSE_IRQ  = 3'd5
   } cause_e;
endpackage

// File: rtl/exc_status_reg.sv
`timescale 1ns/1ps
module exc_status_reg
   import exc_vec_pkg::*;
#(
   parameter int unsigned SW = STAT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_data,
   input  logic          nmi,
   output logic [SW-1:0] status_q
);
   for (genvar i = 0; i < SW; i++) begin : g_bit
      if (i == SB_REVEND) begin : g_tied
         assign status_q[i] = 1'b0;
      end else if (i == SB_BOOTV) begin : g_boot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status_q[i] <= STAT_RST[i];
            else if (nmi)    status_q[i] <= 1'b1;
            else if (wr_en)  status_q[i] <= wr_data[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status_q[i] <= STAT_RST[i];
            else if (wr_en)  status_q[i] <= wr_data[i];
         end
      end
   end
endmodule

// File: rtl/exc_prio_sel.sv
`timescale 1ns/1ps
module exc_prio_sel
   import exc_vec_pkg::*;
#(
   parameter int unsigned IRQ_W = 8
) (
   input  logic             nmi,
   input  logic             miss,
   input  logic             exc,
   input  logic             par,
   input  logic             par_mask,
   input  logic             int_en,
   input  logic [IRQ_W-1:0] irq_pend,
   output cause_e           cause
);
   logic irq_any;
   assign irq_any = |irq_pend;

   always_comb begin
      if (nmi)                   cause = CAUSE_NMI;
      else if (miss)             cause = CAUSE_MISS;
      else if (exc)              cause = CAUSE_EXC;
      else if (par && !par_mask) cause = CAUSE_PAR;
      else if (int_en && irq_any) cause = CAUSE_IRQ;
      else                       cause = CAUSE_NONE;
   end
endmodule

// File: rtl/exc_vec_gen.sv
`timescale 1ns/1ps
module exc_vec_gen
   import exc_vec_pkg::*;
#(
   parameter int unsigned VA_W = 64
) (
   input  cause_e          cause,
   input  logic            boot_vec,
   input  logic [1:0]      miss_seg,
   input  logic            kwide,
   input  logic            swide,
   input  logic            uwide,
   output logic [VA_W-1:0] vec_addr,
   output logic            wide_sel
);
   logic        seg_wide;
   logic [31:0] base, miss_v, addr32;

   always_comb begin
      unique case (priv_e'(miss_seg))
         PRIV_KERN: seg_wide = kwide;
         PRIV_SUP:  seg_wide = swide;
         PRIV_USR:  seg_wide = uwide;
         default:   seg_wide = 1'b0;
      endcase
   end

   assign base   = boot_vec ? BOOT_BASE : NORM_BASE;
   assign miss_v = base + (boot_vec ? BOOT_MISS : NORM_MISS);

   always_comb begin
      wide_sel = 1'b0;
      case (cause)
         CAUSE_NMI:  addr32 = BOOT_BASE;
         CAUSE_MISS: begin
            wide_sel = seg_wide;
            addr32   = seg_wide ? (miss_v + WIDE_OFF) : miss_v;
         end
         CAUSE_EXC, CAUSE_PAR, CAUSE_IRQ: addr32 = miss_v + GEN_OFF;
         default:    addr32 = 32'h0;
      endcase
   end

   if (VA_W > 32) begin : g_sext
      assign vec_addr = {{(VA_W-32){addr32[31]}}, addr32};
   end else begin : g_narrow
      assign vec_addr = addr32;
   end
endmodule

// File: rtl/exc_vec_ctl.sv
`timescale 1ns/1ps
module exc_vec_ctl
   import exc_vec_pkg::*;
#(
   parameter int unsigned VA_W  = 64,
   parameter int unsigned IRQ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_wr_en,
   input  logic [7:0]       st_wr_data,
   output logic [7:0]       st_rd,
   input  logic [1:0]       priv_mode,
   input  logic             miss_req,
   input  logic [1:0]       miss_seg,
   input  logic             exc_req,
   input  logic             par_err_req,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic             nmi_req,
   output logic             vec_valid,
   output logic [VA_W-1:0]  vec_addr,
   output logic             wide_miss,
   output logic             irq_take,
   output logic             par_raise,
   output logic [2:0]       op64_ok,
   output logic             op64_cur
);
   localparam int unsigned NMODE = 3;

   if (VA_W < 32 || VA_W > 64) begin : g_bad_va
      $error("exc_vec_ctl: VA_W must lie in 32..64");
   end
   if (IRQ_W < 1) begin : g_bad_irq
      $error("exc_vec_ctl: IRQ_W must be at least 1");
   end

   logic [STAT_W-1:0] status;
   cause_e            cause;
   logic              wide_sel;

   exc_status_reg #(.SW(STAT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr_en(st_wr_en), .wr_data(st_wr_data),
      .nmi(nmi_req), .status_q(status)
   );

   exc_prio_sel #(.IRQ_W(IRQ_W)) u_prio (
      .nmi(nmi_req), .miss(miss_req), .exc(exc_req), .par(par_err_req),
      .par_mask(status[SB_PARMSK]), .int_en(status[SB_INTEN]),
      .irq_pend(irq_pend), .cause(cause)
   );

   exc_vec_gen #(.VA_W(VA_W)) u_gen (
      .cause(cause), .boot_vec(status[SB_BOOTV]), .miss_seg(miss_seg),
      .kwide(status[SB_KWIDE]), .swide(status[SB_SWIDE]), .uwide(status[SB_UWIDE]),
      .vec_addr(vec_addr), .wide_sel(wide_sel)
   );

   assign st_rd     = status;
   assign vec_valid = (cause != CAUSE_NONE);
   assign wide_miss = wide_sel;
   assign irq_take  = (cause == CAUSE_IRQ);
   assign par_raise = (cause == CAUSE_PAR);

   for (genvar m = 0; m < NMODE; m++) begin : g_mode
      if (m == 0) begin : g_kern
         assign op64_ok[m] = 1'b1;
      end else begin : g_lower
         assign op64_ok[m] = status[SB_KWIDE + m];
      end
   end

   assign op64_cur = (priv_mode == PRIV_RSVD) ? 1'b0 : op64_ok[priv_mode];
endmodule

// File: rtl/exc_vec_ctl_chk.sv
`timescale 1ns/1ps
module exc_vec_ctl_chk
   import exc_vec_pkg::*;
#(
   parameter int unsigned VA_W  = 64,
   parameter int unsigned IRQ_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             st_wr_en,
   input logic [7:0]       st_wr_data,
   input logic [7:0]       st_rd,
   input logic             miss_req,
   input logic             exc_req,
   input logic             par_err_req,
   input logic [IRQ_W-1:0] irq_pend,
   input logic             nmi_req,
   input logic             vec_valid,
   input logic [VA_W-1:0]  vec_addr,
   input logic             wide_miss,
   input logic             irq_take,
   input logic             par_raise
);
   localparam logic [VA_W-1:0] NMI_V = VA_W'(signed'(BOOT_BASE));

   // R2
   rev_end_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd[SB_REVEND] == 1'b0);
   // R2
   write_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr_en && !nmi_req) |=> (st_rd == ($past(st_wr_data) & 8'hEF)));
   // R3
   nmi_sets_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> st_rd[SB_BOOTV]);
   // R3
   nmi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |-> (vec_valid && vec_addr == NMI_V && !wide_miss && !irq_take && !par_raise));
   // R6
   wide_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wide_miss |-> (miss_req && !nmi_req));
   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (st_rd[SB_INTEN] && (|irq_pend) && !miss_req && !exc_req));
   // R9
   par_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_raise |-> (par_err_req && !st_rd[SB_PARMSK]));
   // R10
   one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wide_miss, par_raise, irq_take}));
   // R10
   hard_req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req || miss_req || exc_req) |-> vec_valid);
endmodule

bind exc_vec_ctl exc_vec_ctl_chk #(.VA_W(VA_W), .IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/exc_vec_ctl_tb.sv
`timescale 1ns/1ps
module exc_vec_ctl_tb;
   localparam int VA_W = 64;
   localparam int IRQ_W = 8;
   localparam int WD_CYC = 100000;

   logic clk = 1'b0;
   logic rst_n;
   logic st_wr_en;
   logic [7:0] st_wr_data, st_rd;
   logic [1:0] priv_mode, miss_seg;
   logic miss_req, exc_req, par_err_req, nmi_req;
   logic [IRQ_W-1:0] irq_pend;
   logic vec_valid, wide_miss, irq_take, par_raise, op64_cur;
   logic [VA_W-1:0] vec_addr;
   logic [2:0] op64_ok;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_st;
   string force_tag = "";

   always #10 clk = ~clk;

   exc_vec_ctl #(.VA_W(VA_W), .IRQ_W(IRQ_W)) u_dut (.*);

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      int cause; // 0 none 1 nmi 2 miss 3 exc 4 par 5 irq
      logic wide, bev;
      logic [63:0] ea;
      logic [2:0] eok;
      logic ecur;
      string vt;
      bev = m_st[5];
      if (nmi_req) cause = 1;
      else if (miss_req) cause = 2;
      else if (exc_req) cause = 3;
      else if (par_err_req && !m_st[6]) cause = 4;
      else if (m_st[0] && irq_pend != 0) cause = 5;
      else cause = 0;
      wide = (miss_seg == 0 && m_st[1]) || (miss_seg == 1 && m_st[2]) ||
             (miss_seg == 2 && m_st[3]);
      case (cause)
         1: begin ea = 64'hFFFF_FFFF_BFC0_0000; vt = "R3"; end
         2: begin
            if (bev) ea = wide ? 64'hFFFF_FFFF_BFC0_0280 : 64'hFFFF_FFFF_BFC0_0200;
            else     ea = wide ? 64'hFFFF_FFFF_8000_0080 : 64'hFFFF_FFFF_8000_0000;
            vt = wide ? "R6" : (bev ? "R4" : "R5");
         end
         3: begin ea = bev ? 64'hFFFF_FFFF_BFC0_0380 : 64'hFFFF_FFFF_8000_0180; vt = bev ? "R4" : "R5"; end
         4: begin ea = bev ? 64'hFFFF_FFFF_BFC0_0380 : 64'hFFFF_FFFF_8000_0180; vt = "R9"; end
         5: begin ea = bev ? 64'hFFFF_FFFF_BFC0_0380 : 64'hFFFF_FFFF_8000_0180; vt = "R8"; end
         default: begin ea = 64'h0; vt = rst_n ? "R10" : "R1"; end
      endcase
      if (force_tag != "") vt = force_tag;
      eok = {m_st[3], m_st[2], 1'b1};
      case (priv_mode)
         2'd0: ecur = 1'b1;
         2'd1: ecur = m_st[2];
         2'd2: ecur = m_st[3];
         default: ecur = 1'b0;
      endcase
      chk(rst_n ? "R2 status" : "R1 status", 128'(st_rd), 128'(m_st));
      chk({vt, " vector"}, 128'({vec_valid, vec_addr}), 128'({cause != 0, ea}));
      chk("R10 flags", 128'({wide_miss, par_raise, irq_take}),
          128'({cause == 2 && wide, cause == 4, cause == 5}));
      chk(force_tag != "" ? force_tag : "R7 op64", 128'({op64_ok, op64_cur}), 128'({eok, ecur}));
   endtask

   task automatic tick();
      #2;
      compare();
      @(posedge clk);
      #1;
      if (!rst_n) m_st = 8'h20;
      else begin
         if (st_wr_en) m_st = st_wr_data & 8'hEF;
         if (nmi_req) m_st[5] = 1'b1;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      st_wr_en = 0; st_wr_data = 0; miss_req = 0; exc_req = 0;
      par_err_req = 0; nmi_req = 0; irq_pend = 0;
   endtask

   task automatic wr(input logic [7:0] v);
      idle();
      st_wr_en = 1; st_wr_data = v;
      tick();
      st_wr_en = 0;
   endtask

   initial begin
      #(WD_CYC * 20);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; idle(); priv_mode = 0; miss_seg = 0; m_st = 8'h20;
      @(negedge clk);
      // R1 reset state
      repeat (3) tick();
      rst_n = 1;
      tick(); tick();

      // R4 R5 R6 R7 sweep of boot bit, widening bits, segment and privilege
      for (int b = 0; b < 2; b++) begin
         for (int w = 0; w < 8; w++) begin
            wr({2'b00, b[0], 1'b0, w[2:0], 1'b1});
            for (int s = 0; s < 4; s++) begin
               for (int p = 0; p < 4; p++) begin
                  idle(); miss_req = 1; miss_seg = s[1:0]; priv_mode = p[1:0];
                  tick();
                  miss_req = 0; exc_req = 1;
                  tick();
               end
            end
         end
      end

      // R2 reverse-endian bit written as 1 reads back 0
      wr(8'hFF); idle(); tick();
      wr(8'h10); idle(); tick();

      // R3 NMI with boot bit clear, and NMI against a clearing write
      wr(8'h0F); idle(); miss_req = 1; exc_req = 1; nmi_req = 1; tick();
      idle(); tick();
      wr(8'h00); idle(); nmi_req = 1; st_wr_en = 1; st_wr_data = 8'h01; tick();
      idle(); tick();

      // R8 interrupt enable off then on
      wr(8'h00); idle(); irq_pend = 8'h80; tick();
      wr(8'h01); idle(); irq_pend = 8'h80; tick();
      irq_pend = 8'h01; tick();

      // R9 parity mask on then off
      wr(8'h41); idle(); par_err_req = 1; irq_pend = 8'h04; tick();
      wr(8'h01); idle(); par_err_req = 1; irq_pend = 8'h04; tick();

      // R10 ranking: exception over parity, miss over exception
      idle(); exc_req = 1; par_err_req = 1; irq_pend = 8'hFF; tick();
      miss_req = 1; tick();

      // R11 cache-check bit has no effect
      force_tag = "R11";
      wr(8'h8F); idle(); miss_req = 1; miss_seg = 2; priv_mode = 1; tick();
      idle(); par_err_req = 1; tick();
      force_tag = "";

      // random mix, all requirements against the model
      for (int i = 0; i < 3000; i++) begin
         st_wr_en    = ($urandom % 8) == 0;
         st_wr_data  = 8'($urandom);
         nmi_req     = ($urandom % 16) == 0;
         miss_req    = ($urandom % 4) == 0;
         exc_req     = ($urandom % 4) == 0;
         par_err_req = ($urandom % 3) == 0;
         irq_pend    = (($urandom % 2) == 0) ? IRQ_W'($urandom) : '0;
         miss_seg    = 2'($urandom);
         priv_mode   = 2'($urandom);
         tick();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule